// File: doc/BRIEF.md
# Windowed UART FIFO Buffer Controller

This block sits between a host bus and the serial shift logic of a UART. It owns two 1024-byte FIFOs, one per direction. The host does not move data a byte at a time through a data register. It reaches the FIFO storage through two address windows and moves a whole run of bytes per access.

To receive, the host reads bytes out of the receive window, where window offset k gives the k-th oldest unreleased byte. It then writes a byte count to the receive control word, and that count frees those bytes. To send, the host writes bytes into the transmit window at offsets from the current write pointer. It then writes a byte count to the transmit control word, and that count hands those bytes to the shifter.

Fill counts, pointers and sticky clamp errors can be read back. Programmable trigger levels drive two level outputs for an interrupt block elsewhere. The receive shifter pushes bytes in and the transmit shifter pops bytes out through plain byte ports.

Top module: `uwin_ctrl`

## Requirements
- R1: After reset both fills and all pointers are zero and both clamp errors are clear. The configuration word reads 0x00650000 (transmit level code 5 in [18:16], receive level code 6 in [22:20]). tx_empty_o is 1, tx_valid_o is 0 and rx_full_o is 0.
- R2: A byte on rx_data_i is stored on each cycle with rx_push_i high. The status word at 0x000 reports the 10-bit receive fill with bits [7:0] in [31:24] and bits [9:8] in [7:6]; all other status bits read zero.
- R3: A read strobe at byte address 0x004+k returns, in bits [7:0] of bus_rdata_o on the following cycle, the k-th oldest unreleased receive byte (k = 0..1019). Upper bits are zero. bus_rdata_o holds its value until the next read strobe.
- R4: Writing N in bits [9:0] to 0x800 releases the oldest N receive bytes. Reading 0x800 returns the sticky receive error in bit 31, the fill in [25:16] and the read pointer in [9:0].
- R5: A release count above min(receive fill, 1020), or a commit count above min(transmit free space, 1020), is clamped to that limit. The clamp sets bit 31 of that direction's control word, and the bit stays set until reset. Each direction has its own bit.
- R6: A write to byte address 0x400+k stores bits [7:0] at position (write pointer + k) mod 1024, but only when k is below the free space (1023 minus the transmit fill). Otherwise the write is ignored.
- R7: Writing N in bits [9:0] to 0x804 commits N bytes and advances the write pointer by N. Reading 0x804 returns the sticky transmit error in bit 31, the fill in [25:16] and the write pointer in [9:0].
- R8: tx_valid_o is high when the transmit fill is non-zero, and tx_data_o is then the oldest committed byte. tx_pop_i removes that byte. A pop while empty has no effect. tx_empty_o is high exactly when the transmit fill is zero.
- R9: Each FIFO holds at most 1023 bytes. rx_full_o is high at that fill, and a push while full is dropped without changing the stored data or the fill.
- R10: Writing 0x808 sets the level codes, which read back in place. For a code c the threshold is 2^(c+2) bytes. rx_avail_o is (receive fill >= receive threshold), and tx_space_o is (transmit fill <= transmit threshold).
- R11: All pointers and window offsets wrap modulo 1024, so windows and counts stay correct when a run crosses the end of storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Host write strobe |
| bus_re_i | input | 1 | Host read strobe |
| bus_addr_i | input | 12 | Host byte address |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Registered host read data |
| rx_push_i | input | 1 | Receive shifter byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_full_o | output | 1 | Receive FIFO at capacity |
| tx_pop_i | input | 1 | Transmit shifter takes a byte |
| tx_data_o | output | 8 | Oldest committed transmit byte |
| tx_valid_o | output | 1 | Transmit byte available |
| rx_avail_o | output | 1 | Receive fill at or above its trigger level |
| tx_space_o | output | 1 | Transmit fill at or below its trigger level |
| tx_empty_o | output | 1 | Transmit FIFO empty |

## Verification
The bench fills the receive side to capacity and pushes one extra byte. A design with a wrong full test would wrap the fill back to zero. It then releases 1023 bytes, where a design that ignores the 1020-byte transfer limit would empty the FIFO instead of leaving three bytes. It also checks that window reads past the storage end fetch the right wrapped byte.

On the transmit side it fills the FIFO completely and then writes into the window with no free space. The target of that write is a queued byte, so a missing free-space guard shows up as a corrupted byte at pop time. It also pops while empty, which a design without the empty guard would turn into an underflowed fill. The trigger tests set the thresholds exactly at the fill, which exposes `>` versus `>=` mistakes and a narrow code+2 sum.

// File: rtl/uwin_pkg.sv
package uwin_pkg;
  localparam int unsigned BUS_AW = 12;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned LVL_W  = 3;

  localparam logic [BUS_AW-1:0] A_STATUS  = 12'h000;
  localparam logic [BUS_AW-1:0] A_RX_WIN  = 12'h004;
  localparam logic [BUS_AW-1:0] A_TX_WIN  = 12'h400;
  localparam logic [BUS_AW-1:0] A_RX_CTRL = 12'h800;
  localparam logic [BUS_AW-1:0] A_TX_CTRL = 12'h804;
  localparam logic [BUS_AW-1:0] A_CONFIG  = 12'h808;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_RXWIN,
    SEL_RXCTRL,
    SEL_TXCTRL,
    SEL_CONFIG
  } rd_sel_e;
endpackage

// File: rtl/uwin_level_cmp.sv
module uwin_level_cmp #(
  parameter int unsigned PW       = 10,
  parameter bit          AT_LEAST = 1'b1
) (
  input  logic [PW-1:0] fill_i,
  input  logic [2:0]    code_i,
  output logic          hit_o
);
  logic [PW:0] thr;
  logic [3:0]  shamt;

  // 4-bit sum so codes 6 and 7 do not wrap
  assign shamt = {1'b0, code_i} + 4'd2;
  assign thr   = {{PW{1'b0}}, 1'b1} << shamt;

  generate
    if (AT_LEAST) begin : g_ge
      assign hit_o = {1'b0, fill_i} >= thr;
    end else begin : g_le
      assign hit_o = {1'b0, fill_i} <= thr;
    end
  endgenerate
endmodule

// File: rtl/uwin_rx_fifo.sv
module uwin_rx_fifo #(
  parameter int unsigned DEPTH    = 1024,  // power of two
  parameter int unsigned MAX_XFER = 1020,
  parameter int unsigned PW       = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [7:0]    push_data_i,
  output logic          full_o,
  input  logic          rel_i,
  input  logic [PW-1:0] rel_cnt_i,
  input  logic [PW-1:0] win_off_i,
  output logic [7:0]    win_data_o,
  output logic [PW-1:0] fill_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic          err_o
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH - 1);
  localparam logic [PW-1:0] XFER_LIM = PW'(MAX_XFER);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, fill_q;
  logic          err_q;
  logic          do_push, over;
  logic [PW-1:0] lim, rel_n;

  assign full_o  = (fill_q == FULL_LVL);
  assign do_push = push_i & ~full_o;
  assign lim     = (fill_q < XFER_LIM) ? fill_q : XFER_LIM;
  assign over    = rel_i && (rel_cnt_i > lim);
  assign rel_n   = !rel_i ? '0 : (over ? lim : rel_cnt_i);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      rd_ptr_q <= rd_ptr_q + rel_n;
      fill_q   <= fill_q + {{(PW-1){1'b0}}, do_push} - rel_n;
      if (over) err_q <= 1'b1;
    end
  end

  assign win_data_o = mem_q[rd_ptr_q + win_off_i];
  assign fill_o     = fill_q;
  assign rd_ptr_o   = rd_ptr_q;
  assign err_o      = err_q;

  AST_RX_DROP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !rel_i |=> fill_q == $past(fill_q)); // R9
  AST_RX_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i && !push_i && rel_cnt_i >= fill_q && fill_q <= XFER_LIM |=> fill_q == '0); // R5
  AST_RX_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R5
  AST_RX_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_i |=> $stable(rd_ptr_q)); // R4
endmodule

// File: rtl/uwin_tx_fifo.sv
module uwin_tx_fifo #(
  parameter int unsigned DEPTH    = 1024,  // power of two
  parameter int unsigned MAX_XFER = 1020,
  parameter int unsigned PW       = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          win_we_i,
  input  logic [PW-1:0] win_off_i,
  input  logic [7:0]    win_data_i,
  input  logic          commit_i,
  input  logic [PW-1:0] commit_cnt_i,
  input  logic          pop_i,
  output logic [7:0]    pop_data_o,
  output logic          valid_o,
  output logic [PW-1:0] fill_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic          err_o
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH - 1);
  localparam logic [PW-1:0] XFER_LIM = PW'(MAX_XFER);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, fill_q;
  logic          err_q;
  logic [PW-1:0] free, lim, com_n;
  logic          win_ok, over, do_pop;

  assign free    = FULL_LVL - fill_q;
  assign win_ok  = win_we_i && (win_off_i < free);
  assign lim     = (free < XFER_LIM) ? free : XFER_LIM;
  assign over    = commit_i && (commit_cnt_i > lim);
  assign com_n   = !commit_i ? '0 : (over ? lim : commit_cnt_i);
  assign valid_o = (fill_q != '0);
  assign do_pop  = pop_i & valid_o;

  always_ff @(posedge clk_i) begin
    if (win_ok) mem_q[wr_ptr_q + win_off_i] <= win_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_q + com_n;
      if (do_pop) rd_ptr_q <= rd_ptr_q + 1'b1;
      fill_q   <= fill_q + com_n - {{(PW-1){1'b0}}, do_pop};
      if (over) err_q <= 1'b1;
    end
  end

  assign pop_data_o = mem_q[rd_ptr_q];
  assign fill_o     = fill_q;
  assign wr_ptr_o   = wr_ptr_q;
  assign err_o      = err_q;

  AST_TX_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !valid_o && !commit_i |=> fill_q == '0 && $stable(rd_ptr_q)); // R8
  AST_TX_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !pop_i && commit_cnt_i >= free && free <= XFER_LIM |=> fill_q == FULL_LVL); // R5
  AST_TX_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R5
  AST_TX_WPTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(wr_ptr_q)); // R7
endmodule

// File: rtl/uwin_ctrl.sv
module uwin_ctrl
  import uwin_pkg::*;
#(
  parameter int unsigned DEPTH      = 1024,
  parameter int unsigned MAX_XFER   = 1020,
  parameter logic [2:0]  TX_LVL_RST = 3'd5,
  parameter logic [2:0]  RX_LVL_RST = 3'd6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  input  logic              rx_push_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_full_o,
  input  logic              tx_pop_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              rx_avail_o,
  output logic              tx_space_o,
  output logic              tx_empty_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  rd_sel_e       sel;
  logic          tx_win_hit, rel_we, com_we, cfg_we;
  logic [PW-1:0] rx_off, tx_off, cnt;
  logic [PW-1:0] rx_fill, rx_rptr, tx_fill, tx_wptr;
  logic          rx_err, tx_err;
  logic [7:0]    rx_win_byte;
  logic [2:0]    tx_lvl_q, rx_lvl_q;
  logic [9:0]    rx_fill10;
  logic [BUS_DW-1:0] rd_word, rdata_q;
  logic          unused_wdata;

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr_i >= A_RX_WIN && bus_addr_i < A_TX_WIN) sel = SEL_RXWIN;
    else if (bus_addr_i == A_STATUS)                      sel = SEL_STATUS;
    else if (bus_addr_i == A_RX_CTRL)                     sel = SEL_RXCTRL;
    else if (bus_addr_i == A_TX_CTRL)                     sel = SEL_TXCTRL;
    else if (bus_addr_i == A_CONFIG)                      sel = SEL_CONFIG;
  end

  assign tx_win_hit = bus_addr_i >= A_TX_WIN && bus_addr_i < A_RX_CTRL;
  assign rel_we     = bus_we_i && sel == SEL_RXCTRL;
  assign com_we     = bus_we_i && sel == SEL_TXCTRL;
  assign cfg_we     = bus_we_i && sel == SEL_CONFIG;
  assign rx_off     = PW'(bus_addr_i - A_RX_WIN);
  assign tx_off     = PW'(bus_addr_i - A_TX_WIN);
  assign cnt        = bus_wdata_i[PW-1:0];
  assign unused_wdata = ^{bus_wdata_i[31:23], bus_wdata_i[19], bus_wdata_i[15:PW]};

  uwin_rx_fifo #(.DEPTH(DEPTH), .MAX_XFER(MAX_XFER), .PW(PW)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_push_i),
    .push_data_i (rx_data_i),
    .full_o      (rx_full_o),
    .rel_i       (rel_we),
    .rel_cnt_i   (cnt),
    .win_off_i   (rx_off),
    .win_data_o  (rx_win_byte),
    .fill_o      (rx_fill),
    .rd_ptr_o    (rx_rptr),
    .err_o       (rx_err)
  );

  uwin_tx_fifo #(.DEPTH(DEPTH), .MAX_XFER(MAX_XFER), .PW(PW)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .win_we_i     (bus_we_i && tx_win_hit),
    .win_off_i    (tx_off),
    .win_data_i   (bus_wdata_i[7:0]),
    .commit_i     (com_we),
    .commit_cnt_i (cnt),
    .pop_i        (tx_pop_i),
    .pop_data_o   (tx_data_o),
    .valid_o      (tx_valid_o),
    .fill_o       (tx_fill),
    .wr_ptr_o     (tx_wptr),
    .err_o        (tx_err)
  );

  uwin_level_cmp #(.PW(PW), .AT_LEAST(1'b1)) u_rx_lvl (
    .fill_i (rx_fill),
    .code_i (rx_lvl_q),
    .hit_o  (rx_avail_o)
  );

  uwin_level_cmp #(.PW(PW), .AT_LEAST(1'b0)) u_tx_lvl (
    .fill_i (tx_fill),
    .code_i (tx_lvl_q),
    .hit_o  (tx_space_o)
  );

  assign tx_empty_o = (tx_fill == '0);
  assign rx_fill10  = 10'(rx_fill);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_lvl_q <= TX_LVL_RST;
      rx_lvl_q <= RX_LVL_RST;
    end else if (cfg_we) begin
      tx_lvl_q <= bus_wdata_i[18:16];
      rx_lvl_q <= bus_wdata_i[22:20];
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (sel)
      SEL_STATUS: rd_word = {rx_fill10[7:0], 16'h0, rx_fill10[9:8], 6'h0};
      SEL_RXWIN:  rd_word[7:0] = rx_win_byte;
      SEL_RXCTRL: begin
        rd_word[31]      = rx_err;
        rd_word[16 +: PW] = rx_fill;
        rd_word[0 +: PW]  = rx_rptr;
      end
      SEL_TXCTRL: begin
        rd_word[31]      = tx_err;
        rd_word[16 +: PW] = tx_fill;
        rd_word[0 +: PW]  = tx_wptr;
      end
      SEL_CONFIG: begin
        rd_word[22:20] = rx_lvl_q;
        rd_word[18:16] = tx_lvl_q;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_re_i) rdata_q <= rd_word;
  end

  assign bus_rdata_o = rdata_q;

  AST_EMPTY_NOVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> !tx_valid_o); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |=> $stable(bus_rdata_o)); // R3
  AST_FULL_NOT_EMPTY_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |-> rx_avail_o); // R10
endmodule

// File: tb/sim_uwin_ctrl.sv
module sim_uwin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_full;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid, rx_avail, tx_space, tx_empty;

  int n_chk = 0;
  int n_bad = 0;
  int rx_j  = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  uwin_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_full_o(rx_full),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .rx_avail_o(rx_avail), .tx_space_o(tx_space), .tx_empty_o(tx_empty)
  );

  function automatic logic [7:0] rxd(int j);
    return 8'((j * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] txe(int k);
    return 8'(k) ^ 8'h5A;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0;
    d = rdata;
  endtask

  task automatic push_burst(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rx_push = 1'b1; rx_data = rxd(rx_j); rx_j++;
    end
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pop_chk(string req, logic [7:0] exp);
    @(negedge clk);
    chk(req, {24'h0, tx_data}, {24'h0, exp});
    tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(12'h000, d); chk("R1 status", d, 32'h0);
    bus_rd(12'h800, d); chk("R1 rxctrl", d, 32'h0);
    bus_rd(12'h804, d); chk("R1 txctrl", d, 32'h0);
    bus_rd(12'h808, d); chk("R1 config", d, 32'h0065_0000);
    chk("R1 tx_empty", {31'h0, tx_empty}, 32'h1);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R1 rx_full", {31'h0, rx_full}, 32'h0);
    chk("R10 rx_avail at 0", {31'h0, rx_avail}, 32'h0);
    chk("R10 tx_space at 0", {31'h0, tx_space}, 32'h1);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    push_burst(300);
    bus_rd(12'h000, d); chk("R2 split fill", d, 32'h2C00_0040);
    chk("R10 rx_avail 300>=256", {31'h0, rx_avail}, 32'h1);
    bus_rd(12'h004, d); chk("R3 win off0", d, {24'h0, rxd(0)});
    bus_rd(12'h005, d); chk("R3 win off1", d, {24'h0, rxd(1)});
    bus_rd(12'h12F, d); chk("R3 win off299", d, {24'h0, rxd(299)});
    @(negedge clk); chk("R3 rdata hold", rdata, {24'h0, rxd(299)});
    bus_wr(12'h800, 32'd100);
    bus_rd(12'h800, d); chk("R4 rxctrl after release", d, 32'h00C8_0064);
    chk("R10 rx_avail 200", {31'h0, rx_avail}, 32'h0);
    bus_rd(12'h004, d); chk("R4 oldest after release", d, {24'h0, rxd(100)});
  endtask

  task automatic t_rx_full;
    logic [31:0] d;
    push_burst(823);
    chk("R9 rx_full", {31'h0, rx_full}, 32'h1);
    @(negedge clk); rx_push = 1'b1; rx_data = 8'hFF;
    @(negedge clk); rx_push = 1'b0;
    bus_rd(12'h800, d); chk("R9 push dropped", d, 32'h03FF_0064);
    bus_rd(12'h004, d); chk("R9 data intact", d, {24'h0, rxd(100)});
    bus_wr(12'h800, 32'd1023);
    bus_rd(12'h800, d); chk("R5 rx clamp 1020", d, 32'h8003_0060);
    bus_rd(12'h004, d); chk("R11 rx wrap off0", d, {24'h0, rxd(1120)});
    bus_rd(12'h006, d); chk("R11 rx wrap off2", d, {24'h0, rxd(1122)});
    bus_wr(12'h800, 32'd10);
    bus_rd(12'h800, d); chk("R5 rx clamp fill sticky", d, 32'h8000_0063);
    chk("R9 rx_full cleared", {31'h0, rx_full}, 32'h0);
    bus_rd(12'h000, d); chk("R2 status empty", d, 32'h0);
  endtask

  task automatic t_tx_basic;
    logic [31:0] d;
    for (int k = 0; k < 10; k++) bus_wr(12'h400 + 12'(k), 32'(8'hA0 + k));
    bus_rd(12'h804, d); chk("R7 no commit yet", d, 32'h0);
    chk("R8 no valid before commit", {31'h0, tx_valid}, 32'h0);
    bus_wr(12'h804, 32'd10);
    bus_rd(12'h804, d); chk("R7 commit 10", d, 32'h000A_000A);
    chk("R8 valid", {31'h0, tx_valid}, 32'h1);
    chk("R8 not empty", {31'h0, tx_empty}, 32'h0);
    chk("R10 tx_space 10<=128", {31'h0, tx_space}, 32'h1);
    for (int k = 0; k < 3; k++) pop_chk("R8 pop order", 8'hA0 + 8'(k));
    bus_rd(12'h804, d); chk("R8 fill after pops", d, 32'h0007_000A);
  endtask

  task automatic t_tx_wrap;
    logic [31:0] d;
    for (int k = 0; k < 1016; k++) bus_wr(12'h400 + 12'(k), {24'h0, txe(k)});
    bus_wr(12'h804, 32'd1016);
    bus_rd(12'h804, d); chk("R11 tx wptr wrap", d, 32'h03FF_0002);
    chk("R10 tx_space full", {31'h0, tx_space}, 32'h0);
    bus_wr(12'h405, 32'h0000_00EE);
    bus_wr(12'h804, 32'd5);
    bus_rd(12'h804, d); chk("R5 tx clamp err", d, 32'h83FF_0002);
    for (int k = 3; k < 10; k++) pop_chk("R6 guarded byte", 8'hA0 + 8'(k));
    for (int k = 0; k < 1016; k++) pop_chk("R11 tx wrapped data", txe(k));
    chk("R8 empty after drain", {31'h0, tx_empty}, 32'h1);
    chk("R8 valid low after drain", {31'h0, tx_valid}, 32'h0);
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
    bus_rd(12'h804, d); chk("R8 pop empty ignored", d, 32'h8000_0002);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    bus_wr(12'h808, 32'h0020_0000);
    bus_rd(12'h808, d); chk("R10 config readback", d, 32'h0020_0000);
    push_burst(15);
    chk("R10 rx 15<16", {31'h0, rx_avail}, 32'h0);
    push_burst(1);
    chk("R10 rx 16>=16", {31'h0, rx_avail}, 32'h1);
    chk("R10 tx 0<=4", {31'h0, tx_space}, 32'h1);
    for (int k = 0; k < 4; k++) bus_wr(12'h400 + 12'(k), 32'(k));
    bus_wr(12'h804, 32'd4);
    chk("R10 tx 4<=4", {31'h0, tx_space}, 32'h1);
    bus_wr(12'h400, 32'h0000_0055);
    bus_wr(12'h804, 32'd1);
    chk("R10 tx 5>4", {31'h0, tx_space}, 32'h0);
    bus_wr(12'h808, 32'h0070_0000);
    chk("R10 rx code7 16<512", {31'h0, rx_avail}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rx_basic();
    t_rx_full();
    t_tx_basic();
    t_tx_wrap();
    t_levels();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule